// File: doc/BRIEF.md
# Security-Partitioned Interrupt Register Bank

This block is the state store behind the register interface of an interrupt controller in which every external interrupt is assigned to either the secure or the non-secure world. For each interrupt it holds an enable flag, a pending flag, an 8-bit priority and a target-world flag. An activity flag arrives from the exception logic and can be read back. A plain 32-bit word-addressed port carries reads and writes, and each access is tagged as secure or non-secure.

The target-world flag decides what a non-secure access can see. When an interrupt belongs to the secure world, a non-secure access reads zero in that interrupt's bit or byte of every other register, and its writes to that bit or byte are dropped. Secure accesses see everything. Only secure accesses can read or change the target-world flags. When the security option is built out, every interrupt is non-secure and cannot be moved. A rising edge on an interrupt line marks that interrupt pending. For the arbitration logic further down, the block presents, for each interrupt, a request that is asserted when the interrupt is both enabled and pending, and the interrupt's world flag.

Byte offsets below are given as the word address times four. Reads are combinational: `bus_rdata` is valid in the same cycle that `bus_valid` is high with `bus_write` low, and it is zero at all other times. Writes take effect at the rising clock edge that samples them.

Top module: `irq_secbank`

## Requirements
- R1: Writing 1 to bit b of the word at byte offset 0x100+4w enables interrupt 32w+b. Writing 1 to the same bit at 0x180+4w disables it. Bits written as 0 change nothing. A read at either offset returns the enable flags.
- R2: The same scheme applies to pending flags at 0x200+4w (set) and 0x280+4w (clear). A read at either offset returns the pending flags.
- R3: A read at 0x300+4w returns bit b as the activity input of interrupt 32w+b. Writes there have no effect.
- R4: The word at 0x400+4w holds the priorities of interrupts 4w to 4w+3. Interrupt 4w+k uses bits 8k+7..8k. Each byte can be read and written.
- R5: The word at 0x380+4w (w < 16) holds the target-world flags of interrupts 32w..32w+31, one bit each, where 1 means non-secure. Secure accesses read and write them. A non-secure read returns 0, and a non-secure write is dropped.
- R6: On a non-secure access to the enable, pending or activity words, every bit of an interrupt whose world flag is 0 reads as 0, and writes to that bit are dropped.
- R7: On a non-secure access to a priority word, every byte of an interrupt whose world flag is 0 reads as 0, and writes to that byte are dropped.
- R8: Bits and bytes of interrupt numbers at or above NUM_IRQ read as 0 and ignore writes. Every offset not named in this list reads as 0 and ignores writes.
- R9: With SEC_EXT=1, reset clears every world flag to 0, along with all enable, pending and priority state. With SEC_EXT=0, every world flag is fixed at 1, and the target-world words read as 0 and ignore writes, including secure writes.
- R10: A read at offset 0x004 returns NUM_IRQ/32 - 1.
- R11: A rising edge on `irq_in[i]` sets pending flag i at the clock edge that samples it, whatever the interrupt's world. This set takes precedence over a clear-pending write in the same cycle. A line held high does not set the flag again.
- R12: `irq_req[i]` is 1 when interrupt i is both enabled and pending. `irq_ns[i]` equals its world flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | 1 = secure access |
| bus_waddr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_in | input | NUM_IRQ | External interrupt lines |
| act_in | input | NUM_IRQ | Activity flags from the exception logic |
| irq_req | output | NUM_IRQ | Enabled-and-pending request per interrupt |
| irq_ns | output | NUM_IRQ | Target-world flag per interrupt |

## Verification
Read data is due in the same cycle as the read request. The bench drives the read on a falling edge and samples one nanosecond later, before the next rising edge. A write, or a rising edge on an interrupt line, shows up in the stored state and in `irq_req`/`irq_ns` right after the rising edge that samples it. The bench therefore updates its arithmetic model at that edge and compares on the following half cycle. Edge-versus-clear collisions are staged within that single cycle, so the precedence rule is exercised exactly at the sampling edge.

// File: rtl/irq_secbank_pkg.sv
package irq_secbank_pkg;
   localparam int ADDR_W = 10;
   localparam int WORD_W = 32;
   localparam int PRIO_W = 8;
   localparam int PRIO_PER_WORD = WORD_W / PRIO_W;

   // word-address bits [9:5] select a 128-byte bit-register region
   localparam logic [4:0] RG_SETEN = 5'd2;
   localparam logic [4:0] RG_CLREN = 5'd3;
   localparam logic [4:0] RG_SETPD = 5'd4;
   localparam logic [4:0] RG_CLRPD = 5'd5;
   localparam logic [4:0] RG_ACT   = 5'd6;
   localparam logic [4:0] RG_TGT   = 5'd7;
   localparam logic [1:0] PRIO_HI  = 2'b01;
   localparam logic [ADDR_W-1:0] WA_CTYPE = 10'd1;

   typedef struct packed {
      logic set_en;
      logic clr_en;
      logic set_pd;
      logic clr_pd;
      logic prio_we;
   } slot_cmd_t;
endpackage

// File: rtl/irq_secbank_slot.sv
module irq_secbank_slot
   import irq_secbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  slot_cmd_t         cmd_i,
   input  logic [PRIO_W-1:0] prio_wd_i,
   input  logic              rise_i,
   output logic              en_o,
   output logic              pend_o,
   output logic [PRIO_W-1:0] prio_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         pend_o <= 1'b0;
         prio_o <= '0;
      end else begin
         if (cmd_i.set_en)      en_o <= 1'b1;
         else if (cmd_i.clr_en) en_o <= 1'b0;
         // a line edge outranks a clear in the same cycle
         if (rise_i || cmd_i.set_pd) pend_o <= 1'b1;
         else if (cmd_i.clr_pd)      pend_o <= 1'b0;
         if (cmd_i.prio_we) prio_o <= prio_wd_i;
      end
   end
endmodule

// File: rtl/irq_secbank_tgt.sv
module irq_secbank_tgt
   import irq_secbank_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [4:0]         word_i,
   input  logic [WORD_W-1:0]  wdata_i,
   output logic [NUM_IRQ-1:0] tns_o
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      localparam int W = i / WORD_W;
      localparam int B = i % WORD_W;
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         q <= 1'b0;
         else if (we_i && word_i == 5'(W))   q <= wdata_i[B];
      end
      assign tns_o[i] = q;
   end
endmodule

// File: rtl/irq_secbank_rdmux.sv
module irq_secbank_rdmux
   import irq_secbank_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter bit SEC_EXT = 1'b1
) (
   input  logic                      rd_i,
   input  logic                      secure_i,
   input  logic [ADDR_W-1:0]         waddr_i,
   input  logic [NUM_IRQ-1:0]        en_i,
   input  logic [NUM_IRQ-1:0]        pend_i,
   input  logic [NUM_IRQ-1:0]        act_i,
   input  logic [NUM_IRQ-1:0]        tns_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   output logic [WORD_W-1:0]         rdata_o
);
   localparam int NWORDS = NUM_IRQ / WORD_W;
   localparam int PWORDS = NUM_IRQ / PRIO_PER_WORD;

   logic [NUM_IRQ-1:0] vis, src;
   logic [4:0] rg;

   always_comb begin
      vis     = secure_i ? '1 : tns_i;
      rg      = waddr_i[9:5];
      rdata_o = '0;
      unique case (rg)
         RG_SETEN, RG_CLREN: src = en_i & vis;
         RG_SETPD, RG_CLRPD: src = pend_i & vis;
         RG_ACT:             src = act_i & vis;
         RG_TGT:             src = (SEC_EXT && secure_i && !waddr_i[4]) ? tns_i : '0;
         default:            src = '0;
      endcase
      if (rd_i) begin
         if (waddr_i == WA_CTYPE) begin
            rdata_o = WORD_W'(NWORDS - 1);
         end else if (waddr_i[9:8] == PRIO_HI) begin
            for (int w = 0; w < PWORDS; w++) begin
               if (waddr_i[7:0] == 8'(w)) begin
                  for (int k = 0; k < PRIO_PER_WORD; k++) begin
                     if (vis[w*PRIO_PER_WORD+k])
                        rdata_o[k*PRIO_W +: PRIO_W] = prio_i[(w*PRIO_PER_WORD+k)*PRIO_W +: PRIO_W];
                  end
               end
            end
         end else if (rg >= RG_SETEN && rg <= RG_TGT) begin
            for (int w = 0; w < NWORDS; w++) begin
               if (waddr_i[4:0] == 5'(w)) rdata_o = src[w*WORD_W +: WORD_W];
            end
         end
      end
   end
endmodule

// File: rtl/irq_secbank.sv
module irq_secbank
   import irq_secbank_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter bit SEC_EXT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic               bus_secure,
   input  logic [ADDR_W-1:0]  bus_waddr,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic [WORD_W-1:0]  bus_rdata,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [NUM_IRQ-1:0] act_in,
   output logic [NUM_IRQ-1:0] irq_req,
   output logic [NUM_IRQ-1:0] irq_ns
);
   if ((NUM_IRQ % WORD_W) != 0 || NUM_IRQ < WORD_W || NUM_IRQ > 480) begin : g_bad_cfg
      $error("irq_secbank: NUM_IRQ must be a multiple of 32 in 32..480");
   end

   logic wr, rd;
   logic [4:0] rg, wword;
   logic [7:0] pword;
   logic is_prio;
   logic [NUM_IRQ-1:0] irq_prev_q, irq_rise;
   logic [NUM_IRQ-1:0] en_q, pend_q, tns_q;
   logic [NUM_IRQ*PRIO_W-1:0] prio_flat;

   assign wr      = bus_valid & bus_write;
   assign rd      = bus_valid & ~bus_write;
   assign rg      = bus_waddr[9:5];
   assign wword   = bus_waddr[4:0];
   assign pword   = bus_waddr[7:0];
   assign is_prio = (bus_waddr[9:8] == PRIO_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_prev_q <= '0;
      else        irq_prev_q <= irq_in;
   end
   assign irq_rise = irq_in & ~irq_prev_q;

   // target-world flags: stored when the security option exists, tied otherwise
   if (SEC_EXT) begin : g_tgt
      irq_secbank_tgt #(.NUM_IRQ(NUM_IRQ)) u_tgt (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (wr & bus_secure & (rg == RG_TGT) & ~bus_waddr[4]),
         .word_i  (wword),
         .wdata_i (bus_wdata),
         .tns_o   (tns_q)
      );
   end else begin : g_no_tgt
      assign tns_q = '1;
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
      localparam int W  = i / WORD_W;
      localparam int B  = i % WORD_W;
      localparam int PW = i / PRIO_PER_WORD;
      localparam int PB = i % PRIO_PER_WORD;
      logic vis, bit_hit;
      slot_cmd_t cmd;
      always_comb begin
         vis         = bus_secure | tns_q[i];
         bit_hit     = wr & vis & (wword == 5'(W)) & bus_wdata[B];
         cmd.set_en  = bit_hit & (rg == RG_SETEN);
         cmd.clr_en  = bit_hit & (rg == RG_CLREN);
         cmd.set_pd  = bit_hit & (rg == RG_SETPD);
         cmd.clr_pd  = bit_hit & (rg == RG_CLRPD);
         cmd.prio_we = wr & vis & is_prio & (pword == 8'(PW));
      end
      irq_secbank_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_i     (cmd),
         .prio_wd_i (bus_wdata[PB*PRIO_W +: PRIO_W]),
         .rise_i    (irq_rise[i]),
         .en_o      (en_q[i]),
         .pend_o    (pend_q[i]),
         .prio_o    (prio_flat[i*PRIO_W +: PRIO_W])
      );
   end

   irq_secbank_rdmux #(.NUM_IRQ(NUM_IRQ), .SEC_EXT(SEC_EXT)) u_rdmux (
      .rd_i     (rd),
      .secure_i (bus_secure),
      .waddr_i  (bus_waddr),
      .en_i     (en_q),
      .pend_i   (pend_q),
      .act_i    (act_in),
      .tns_i    (tns_q),
      .prio_i   (prio_flat),
      .rdata_o  (bus_rdata)
   );

   assign irq_req = en_q & pend_q;
   assign irq_ns  = tns_q;
endmodule

// File: rtl/irq_secbank_chk.sv
module irq_secbank_chk
   import irq_secbank_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter bit SEC_EXT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_valid,
   input logic               bus_write,
   input logic               bus_secure,
   input logic [ADDR_W-1:0]  bus_waddr,
   input logic [WORD_W-1:0]  bus_rdata,
   input logic [NUM_IRQ-1:0] irq_in,
   input logic [NUM_IRQ-1:0] irq_prev_q,
   input logic [NUM_IRQ-1:0] en_q,
   input logic [NUM_IRQ-1:0] pend_q,
   input logic [NUM_IRQ-1:0] tns_q
);
   logic ns_rd, ns_wr;
   assign ns_rd = bus_valid && !bus_write && !bus_secure;
   assign ns_wr = bus_valid && bus_write && !bus_secure;

   p_ns_tgt_raz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ns_rd && bus_waddr[9:4] == 6'b001110) |-> bus_rdata == '0);

   p_ns_tgt_wi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ns_wr |=> $stable(tns_q));

   p_ns_en_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ns_rd && bus_waddr == 10'h040) |-> (bus_rdata & ~tns_q[WORD_W-1:0]) == '0);

   p_ns_en_wi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ns_wr |=> ((en_q ^ $past(en_q)) & ~$past(tns_q)) == '0);

   p_ctype_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_waddr == WA_CTYPE) |-> bus_rdata == WORD_W'(NUM_IRQ / WORD_W - 1));

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_edge
      p_edge_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_in[i] && !irq_prev_q[i]) |=> pend_q[i]);
   end
endmodule

bind irq_secbank irq_secbank_chk #(.NUM_IRQ(NUM_IRQ), .SEC_EXT(SEC_EXT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_secure (bus_secure),
   .bus_waddr  (bus_waddr),
   .bus_rdata  (bus_rdata),
   .irq_in     (irq_in),
   .irq_prev_q (irq_prev_q),
   .en_q       (en_q),
   .pend_q     (pend_q),
   .tns_q      (tns_q)
);

// File: tb/irq_secbank_tb_top.sv
`timescale 1ns/1ps
module irq_secbank_tb_top;
   localparam int N  = 64;
   localparam int NW = N / 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, bus_valid, bus_write, bus_secure;
   logic [9:0]  bus_waddr;
   logic [31:0] bus_wdata, rdata_a, rdata_b;
   logic [N-1:0] irq_in, act_in, req_a, ns_a, req_b, ns_b;

   irq_secbank #(.NUM_IRQ(N), .SEC_EXT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_secure(bus_secure), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_a), .irq_in(irq_in), .act_in(act_in),
      .irq_req(req_a), .irq_ns(ns_a));

   irq_secbank #(.NUM_IRQ(N), .SEC_EXT(1'b0)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_secure(bus_secure), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_b), .irq_in(irq_in), .act_in(act_in),
      .irq_req(req_b), .irq_ns(ns_b));

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;
   bit m_en[N], m_pd[N], m_tns[N];
   logic [7:0] m_pr[N];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(logic [9:0] a, bit sec);
      int rg = int'(a[9:5]);
      if (a == 10'd1) return "R10 type word";
      if (a[9:8] == 2'b01) return (a[7:0] >= 8'(N/4)) ? "R8 prio range" : (sec ? "R4 prio" : "R7 ns prio");
      if (rg >= 2 && rg <= 7 && int'(a[4:0]) >= NW) return "R8 bit range";
      case (rg)
         2, 3: return sec ? "R1 enable" : "R6 ns enable";
         4, 5: return sec ? "R2 pending" : "R6 ns pending";
         6:    return sec ? "R3 active" : "R6 ns active";
         7:    return "R5 target";
         default: return "R8 unmapped";
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(logic [9:0] a, bit sec);
      logic [31:0] r = '0;
      int rg = int'(a[9:5]);
      int w  = int'(a[4:0]);
      int pw = int'(a[7:0]);
      if (a == 10'd1) return 32'(NW - 1);
      if (a[9:8] == 2'b01) begin
         for (int k = 0; k < 4; k++) begin
            int q = 4 * pw + k;
            if (q < N && (sec || m_tns[q])) r[8*k +: 8] = m_pr[q];
         end
      end else if (rg >= 2 && rg <= 6) begin
         for (int b = 0; b < 32; b++) begin
            int q = 32 * w + b;
            if (q < N && (sec || m_tns[q]))
               r[b] = (rg <= 3) ? m_en[q] : (rg <= 5) ? m_pd[q] : act_in[q];
         end
      end else if (rg == 7 && !a[4] && sec) begin
         for (int b = 0; b < 32; b++) begin
            int q = 32 * w + b;
            if (q < N) r[b] = m_tns[q];
         end
      end
      return r;
   endfunction

   function automatic void model_wr(logic [9:0] a, logic [31:0] d, bit sec);
      int rg = int'(a[9:5]);
      int w  = int'(a[4:0]);
      int pw = int'(a[7:0]);
      if (a[9:8] == 2'b01) begin
         for (int k = 0; k < 4; k++) begin
            int q = 4 * pw + k;
            if (q < N && (sec || m_tns[q])) m_pr[q] = d[8*k +: 8];
         end
      end else if (rg == 7) begin
         if (sec && !a[4])
            for (int b = 0; b < 32; b++) if (32*w+b < N) m_tns[32*w+b] = d[b];
      end else if (rg >= 2 && rg <= 5) begin
         for (int b = 0; b < 32; b++) begin
            int q = 32 * w + b;
            if (q < N && d[b] && (sec || m_tns[q])) begin
               if (rg == 2) m_en[q] = 1;
               if (rg == 3) m_en[q] = 0;
               if (rg == 4) m_pd[q] = 1;
               if (rg == 5) m_pd[q] = 0;
            end
         end
      end
   endfunction

   task automatic wr(logic [9:0] a, logic [31:0] d, bit sec);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_secure = sec; bus_waddr = a; bus_wdata = d;
      @(posedge clk);
      model_wr(a, d, sec);
      #1 bus_valid = 0; bus_write = 0;
   endtask

   task automatic rd(logic [9:0] a, bit sec);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_secure = sec; bus_waddr = a;
      #1 chk(tag_of(a, sec), 64'(rdata_a), 64'(exp_rd(a, sec)));
      bus_valid = 0;
   endtask

   task automatic chk_outs();
      logic [N-1:0] er, en;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         er[i] = m_en[i] & m_pd[i];
         en[i] = m_tns[i];
      end
      chk("R12 irq_req", req_a, er);
      chk("R12 irq_ns", ns_a, en);
      chk("R9 fixed non-secure flags", ns_b, '1);
   endtask

   task automatic sweep(bit sec);
      for (int rg = 2; rg <= 7; rg++)
         for (int w = 0; w <= NW; w++) rd(10'(rg * 32 + w), sec);
      for (int pw = 0; pw <= N / 4; pw++) rd(10'(256 + pw), sec);
   endtask

   initial begin
      rst_n = 0; bus_valid = 0; bus_write = 0; bus_secure = 0;
      bus_waddr = '0; bus_wdata = '0; irq_in = '0; act_in = '0;
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pd[i] = 0; m_tns[i] = 0; m_pr[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R9: reset state, all zero and all secure
      sweep(1); sweep(0); chk_outs();
      rd(10'd1, 1); rd(10'd1, 0);   // R10

      // R5: secure programs world flags, non-secure write dropped
      wr(10'hE0, 32'hA5A5_0F0F, 1);
      wr(10'hE1, 32'h3C3C_FF00, 1);
      wr(10'hE0, 32'hFFFF_FFFF, 0);
      wr(10'hE1, 32'h0000_0000, 0);
      sweep(1); sweep(0); chk_outs();

      // R1 R2 R4 R6 R7 R8: both worlds across every region
      for (int it = 0; it < 48; it++) begin
         bit sec = it[0];
         int reg_k = (it / 2) % 6;
         logic [31:0] d = 32'(it) * 32'h9E37_79B9 ^ 32'h5BD1_E995 * 32'(it + 3);
         logic [9:0] a;
         if (reg_k < 5) a = 10'((2 + reg_k) * 32 + it % 3);
         else           a = 10'(256 + it % 17);
         if (it == 24) wr(10'hE0, 32'h0FF0_55AA, 1);
         wr(a, d, sec);
         sweep(1); sweep(0); chk_outs();
      end

      // R3: activity is read-only and filtered
      act_in = 64'hF0F0_1234_8765_ABCD;
      wr(10'hC0, 32'hFFFF_FFFF, 1);
      sweep(1); sweep(0);

      // R8: unmapped offsets
      wr(10'h0F0, 32'hFFFF_FFFF, 1);
      rd(10'h000, 1); rd(10'h002, 1); rd(10'h0F0, 1); rd(10'h180, 1); rd(10'h3FF, 0);
      sweep(1);

      // R9: security option absent, target words read zero even for secure
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_secure = 1; bus_waddr = 10'hE0;
      #1 chk("R9 no-sec target word", 64'(rdata_b), 64'd0);
      bus_valid = 0;

      // R11: edges set pending regardless of world
      wr(10'hA0, 32'hFFFF_FFFF, 1); wr(10'hA1, 32'hFFFF_FFFF, 1);
      @(negedge clk) irq_in = 64'h8000_0001_0000_0021;
      @(posedge clk); #1;
      for (int i = 0; i < N; i++) if (irq_in[i]) m_pd[i] = 1;
      rd(10'h80, 1); rd(10'h81, 1); rd(10'h80, 0); chk_outs();
      // held high: a clear sticks
      wr(10'hA0, 32'h0000_0021, 1);
      rd(10'h80, 1);
      // edge and clear in one cycle: set wins
      @(negedge clk) irq_in = '0;
      @(negedge clk);
      irq_in[5] = 1; bus_valid = 1; bus_write = 1; bus_secure = 1;
      bus_waddr = 10'hA0; bus_wdata = 32'h0000_0020;
      @(posedge clk);
      model_wr(10'hA0, 32'h0000_0020, 1);
      m_pd[5] = 1;
      #1 bus_valid = 0; bus_write = 0;
      rd(10'h80, 1);
      chk("R11 edge beats clear", 64'(rdata_a[5]), 64'd1);
      chk_outs();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule